// File: doc/BRIEF.md
# Transmit DMA Channel Controller

This block is the control state machine for a transmit DMA channel that processes descriptors. Software writes a command word carrying two self-clearing bits, channel reset and transmit disable. A separate level input chooses how an underrun is handled. The transmit path reports four events as single-cycle pulses: a frame has started, the status of a frame has been written, an underrun occurred, and the reset of the descriptor processor and FIFO has finished.

From these inputs the block keeps a one-hot state: idle, frame active, draining (a halt is pending until the frame's status is written), halted, and resetting. It drives a transmit-active status, a halted flag, an in-frame flag, and a reset request that is held until the reset completes. When an underrun stops the channel it also pulses a descriptor-queue flush and an enqueue-count clear.

A halted channel stays halted until software writes a channel reset. This lets software re-initialise the descriptor processor before transfers start again. Descriptor fetch, the MAC and the FIFO storage are outside this block.

Top module: `txdma_chan_ctl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, the outputs are idle: `tx_active`=1, `halted`=0, `reset_req`=0, `in_frame`=0, `q_flush`=0, `enq_clr`=0.
- R2: A command write with `cmd_chan_reset`=1 raises `reset_req` on the next cycle from any state. `reset_req` stays high until `ev_reset_done` is seen. On the cycle after that event the channel is idle again, which means the reset bit has cleared itself.
- R3: If one command write sets both `cmd_chan_reset` and `cmd_tx_disable`, the reset wins and the disable is dropped. A reset written in the same cycle as an underrun also wins, and the flush strobes do not fire.
- R4: A disable write while idle sets `halted` and clears `tx_active` on the next cycle. This holds even when a frame start arrives in the same cycle.
- R5: A disable write during a frame keeps `tx_active`=1 and `in_frame`=1 until `ev_status_done`. `halted` rises on the cycle after that event.
- R6: `tx_active` is 0 exactly when the channel is halted or resetting.
- R7: When `cfg_urun_halt`=1, an underrun during a frame (active or draining) sets `halted` on the next cycle. In that same cycle `q_flush` and `enq_clr` are high for `PULSE_LEN` cycles (default 1).
- R8: When `cfg_urun_halt`=0, an underrun has no effect. The frame stays active, `ev_status_done` returns the channel to idle, and the next frame can start.
- R9: Once halted, the channel ignores frame starts, disable writes, underruns and status events. It leaves the halted state only through a channel reset.
- R10: Status, underrun and reset-done events while idle are ignored. A frame start while resetting is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_chan_reset | input | 1 | Channel reset bit of the command word |
| cmd_tx_disable | input | 1 | Transmit disable bit of the command word |
| cfg_urun_halt | input | 1 | 1: halt and flush on underrun; 0: continue |
| ev_frame_start | input | 1 | Pulse: a transmit frame has begun |
| ev_status_done | input | 1 | Pulse: the current frame's status has been written |
| ev_underrun | input | 1 | Pulse: transmit underrun |
| ev_reset_done | input | 1 | Pulse: descriptor processor and FIFO reset finished |
| tx_active | output | 1 | Transmit DMA not halted and not resetting |
| halted | output | 1 | Channel halted |
| reset_req | output | 1 | Reset request to descriptor processor and FIFO |
| in_frame | output | 1 | A frame is in progress (active or draining) |
| q_flush | output | 1 | Descriptor-queue flush strobe |
| enq_clr | output | 1 | Enqueue-count clear strobe |

## Verification
The assertions assume that every event input is a single-cycle pulse. They also assume that `ev_reset_done` arrives only while a reset is requested and that `ev_status_done` refers to the frame in progress. Because of this, a held-high input would be counted as repeated events. The stimulus drives each input for exactly one cycle, starting at a falling edge, and returns it to zero before the next vector. Out-of-context events are applied only in the cases where R9 and R10 require them to be ignored.

// File: rtl/txc_pkg.sv
package txc_pkg;

  typedef enum logic [4:0] {
    ST_IDLE      = 5'b00001,
    ST_ACTIVE    = 5'b00010,
    ST_DRAIN     = 5'b00100,
    ST_HALTED    = 5'b01000,
    ST_RESETTING = 5'b10000
  } txc_state_e;

  typedef struct packed {
    logic chan_reset;
    logic tx_disable;
  } txc_cmd_t;

  typedef struct packed {
    logic frame_start;
    logic status_done;
    logic underrun;
    logic reset_done;
  } txc_ev_t;

  // underrun that stops the channel (reset written alongside wins)
  function automatic logic txc_urun_stop(txc_state_e s, txc_cmd_t c,
                                         txc_ev_t e, logic urh);
    return !c.chan_reset && urh && e.underrun &&
           (s == ST_ACTIVE || s == ST_DRAIN);
  endfunction

  function automatic txc_state_e txc_next(txc_state_e s, txc_cmd_t c,
                                          txc_ev_t e, logic urh);
    if (c.chan_reset) return ST_RESETTING;
    case (s)
      ST_IDLE: begin
        if (c.tx_disable)       return ST_HALTED;
        else if (e.frame_start) return ST_ACTIVE;
        else                    return ST_IDLE;
      end
      ST_ACTIVE: begin
        if (urh && e.underrun)  return ST_HALTED;
        else if (e.status_done) return c.tx_disable ? ST_HALTED : ST_IDLE;
        else if (c.tx_disable)  return ST_DRAIN;
        else                    return ST_ACTIVE;
      end
      ST_DRAIN: begin
        if ((urh && e.underrun) || e.status_done) return ST_HALTED;
        else                                       return ST_DRAIN;
      end
      ST_HALTED:    return ST_HALTED;
      ST_RESETTING: return e.reset_done ? ST_IDLE : ST_RESETTING;
      default:      return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/txc_cmd_decode.sv
module txc_cmd_decode
  import txc_pkg::*;
(
  input  logic     cmd_wr,
  input  logic     cmd_chan_reset,
  input  logic     cmd_tx_disable,
  output txc_cmd_t cmd_o
);
  // both bits act once per write; reset masks disable
  always_comb begin
    cmd_o.chan_reset = cmd_wr && cmd_chan_reset;
    cmd_o.tx_disable = cmd_wr && cmd_tx_disable && !cmd_chan_reset;
  end
endmodule

// File: rtl/txc_fsm.sv
module txc_fsm
  import txc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  txc_cmd_t   cmd,
  input  txc_ev_t    ev,
  input  logic       urun_halt_en,
  output txc_state_e state,
  output logic       urun_stop
);
  txc_state_e state_nx;

  always_comb begin
    state_nx  = txc_next(state, cmd, ev, urun_halt_en);
    urun_stop = txc_urun_stop(state, cmd, ev, urun_halt_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  p_state_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(state));

  p_reset_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.chan_reset |=> state == ST_RESETTING);

  p_reset_leave_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RESETTING && ev.reset_done && !cmd.chan_reset)
      |=> state == ST_IDLE);

  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALTED && !cmd.chan_reset) |=> state == ST_HALTED);

  p_reset_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.chan_reset |=> !$past(urun_stop));

  p_urun_halts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    urun_stop |=> state == ST_HALTED);
endmodule

// File: rtl/txc_strobe.sv
module txc_strobe #(
  parameter int unsigned PULSE_LEN = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic clr,
  output logic pulse
);
  localparam int unsigned CW = $clog2(PULSE_LEN + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (fire)       cnt <= CW'(PULSE_LEN);
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign pulse = (cnt != '0);

  p_fire_pulses_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !clr) |=> pulse);

  p_clr_stops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pulse);
endmodule

// File: rtl/txdma_chan_ctl.sv
module txdma_chan_ctl
  import txc_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_wr,
  input  logic cmd_chan_reset,
  input  logic cmd_tx_disable,
  input  logic cfg_urun_halt,
  input  logic ev_frame_start,
  input  logic ev_status_done,
  input  logic ev_underrun,
  input  logic ev_reset_done,
  output logic tx_active,
  output logic halted,
  output logic reset_req,
  output logic in_frame,
  output logic q_flush,
  output logic enq_clr
);
  txc_cmd_t   cmd;
  txc_ev_t    ev;
  txc_state_e state;
  logic       urun_stop;
  logic       flush_pulse;

  assign ev = '{frame_start: ev_frame_start, status_done: ev_status_done,
                underrun: ev_underrun, reset_done: ev_reset_done};

  txc_cmd_decode u_cmd (
    .cmd_wr         (cmd_wr),
    .cmd_chan_reset (cmd_chan_reset),
    .cmd_tx_disable (cmd_tx_disable),
    .cmd_o          (cmd)
  );

  txc_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd          (cmd),
    .ev           (ev),
    .urun_halt_en (cfg_urun_halt),
    .state        (state),
    .urun_stop    (urun_stop)
  );

  txc_strobe #(.PULSE_LEN(PULSE_LEN)) u_flush (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (urun_stop),
    .clr   (cmd.chan_reset),
    .pulse (flush_pulse)
  );

  always_comb begin
    halted    = (state == ST_HALTED);
    reset_req = (state == ST_RESETTING);
    in_frame  = (state == ST_ACTIVE) || (state == ST_DRAIN);
    tx_active = !(halted || reset_req);
    q_flush   = flush_pulse;
    enq_clr   = flush_pulse;
  end

  p_no_midframe_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && !ev_status_done && !(ev_underrun && cfg_urun_halt) &&
     !(cmd_wr && cmd_chan_reset)) |=> (in_frame && tx_active));

  p_flush_while_halted_r7: assert property (@(posedge clk) disable iff (!rst_n)
    q_flush |-> halted);

  p_urun_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_urun_halt && in_frame && !ev_status_done && !cmd_wr) |=> in_frame);

  p_idle_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && !in_frame && !ev_frame_start && !cmd_wr)
      |=> (tx_active && !in_frame));
endmodule

// File: tb/test_txdma_chan_ctl.sv
module test_txdma_chan_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 0, cmd_chan_reset = 0, cmd_tx_disable = 0, cfg_urun_halt = 0;
  logic ev_frame_start = 0, ev_status_done = 0, ev_underrun = 0, ev_reset_done = 0;
  logic tx_active, halted, reset_req, in_frame, q_flush, enq_clr;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  txdma_chan_ctl i_txdma_chan_ctl (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_chan_reset(cmd_chan_reset),
    .cmd_tx_disable(cmd_tx_disable), .cfg_urun_halt(cfg_urun_halt),
    .ev_frame_start(ev_frame_start), .ev_status_done(ev_status_done),
    .ev_underrun(ev_underrun), .ev_reset_done(ev_reset_done),
    .tx_active(tx_active), .halted(halted), .reset_req(reset_req),
    .in_frame(in_frame), .q_flush(q_flush), .enq_clr(enq_clr)
  );

  // entry: {req[3:0], wr rst dis urh fs sd ur rd, exp act halt rreq infr flush}
  // expected is the output after the edge that follows the inputs; tx_active (R6) in every row
  localparam int NV = 33;
  localparam logic [16:0] VEC [0:NV-1] = '{
    17'b1010_00010111_10000, // R10 idle ignores status/underrun/reset-done
    17'b1000_00001000_10010, // R8 frame start
    17'b1000_00000010_10010, // R8 underrun without halt: keeps going
    17'b1000_00000100_10000, // R8 status written: back to idle
    17'b0111_00011000_10010, // R7 frame start, halt enabled
    17'b0111_00010010_01001, // R7 underrun: halt plus flush
    17'b0111_00010000_01000, // R7 flush lasts one cycle
    17'b1001_00001000_01000, // R9 frame start ignored
    17'b1001_10100010_01000, // R9 disable and underrun ignored
    17'b0010_11000000_00100, // R2 reset leaves halt
    17'b0010_00000000_00100, // R2 held until done
    17'b1010_00001000_00100, // R10 frame start ignored while resetting
    17'b0010_00000001_10000, // R2 done: idle
    17'b0100_10100000_01000, // R4 disable in idle
    17'b0010_11000000_00100, // R2
    17'b0010_00000001_10000, // R2
    17'b0101_00001000_10010, // R5 frame start
    17'b0101_10100000_10010, // R5 disable mid-frame: still active
    17'b0101_00000000_10010, // R5 waiting for status
    17'b0101_00000100_01000, // R5 status written: halted
    17'b0011_11100000_00100, // R3 reset beats disable
    17'b0010_00000001_10000, // R2
    17'b0111_00011000_10010, // R7 frame
    17'b0111_10110000_10010, // R7 disable: draining
    17'b0111_00010010_01001, // R7 underrun while draining
    17'b0011_11010010_00100, // R3 reset with underrun: no flush
    17'b0010_00000001_10000, // R2
    17'b0100_10101000_01000, // R4 disable beats simultaneous frame start
    17'b0010_11000000_00100, // R2
    17'b0010_00000001_10000, // R2
    17'b0010_00001000_10010, // R2 frame
    17'b0010_11000000_00100, // R2 reset from active
    17'b0010_00000001_10000  // R2
  };

  function automatic logic [4:0] obs();
    return {tx_active, halted, reset_req, in_frame, q_flush};
  endfunction

  task automatic check(input int req, input string what, input logic [4:0] exp);
    n_chk++;
    if (obs() !== exp || q_flush !== enq_clr) begin
      n_bad++;
      $display("FAIL R%0d %s: got %b (enq_clr %b) expected %b", req, what, obs(), enq_clr, exp);
    end
  endtask

  task automatic drive(input logic [7:0] v);
    @(negedge clk);
    {cmd_wr, cmd_chan_reset, cmd_tx_disable, cfg_urun_halt,
     ev_frame_start, ev_status_done, ev_underrun, ev_reset_done} = v;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #20000000;
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #13;
    check(1, "R1 outputs in reset", 5'b10000);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    check(1, "R1 first cycle after reset", 5'b10000);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][12:5]);
      check(int'(VEC[i][16:13]), $sformatf("vector %0d", i), VEC[i][4:0]);
    end
    drive(8'h00);

    // R1: reset asserted mid-frame returns to idle
    drive(8'b00001000);
    check(1, "R1 frame before reset", 5'b10010);
    @(negedge clk); rst_n = 1'b0;
    #2;
    check(1, "R1 async reset mid-frame", 5'b10000);
    @(negedge clk); rst_n = 1'b1;

    // R9: halted stays halted over many idle cycles
    drive(8'b10100000);
    for (int k = 0; k < 20; k++) drive(8'b00000110);
    check(9, "R9 long halt with events", 5'b01000);
    drive(8'b11000000);
    check(2, "R2 reset after long halt", 5'b00100);
    for (int k = 0; k < 5; k++) drive(8'b00000000);
    check(2, "R2 reset held without done", 5'b00100);
    drive(8'b00000001);
    check(2, "R2 reset done", 5'b10000);
    drive(8'h00);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule